// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block produces the element indices for a vector loop that runs over two nested dimensions: a vector length and a sub-vector length. The source side and the destination side each have their own pair of counters, a main step and a sub-step. The main step is 7 bits wide and the sub-step is 2 bits wide. Each advance strobe moves both sides forward by one element position in the same clock edge.

A per-side control bit sets the loop order. When the bit is clear, the sub-step is the inner loop, so all sub-elements of one main element are visited before the main step moves on. When the bit is set, the sub-step becomes the outer loop, so every main element is visited for one sub-element position before the sub-step moves on. The source side uses the pack bit and the destination side uses the unpack bit, so the two sides can walk the same element set in different orders.

Completion is detected on the main step and the sub-step together. An advance taken while either side is on its last element, or an advance taken outside vector mode, returns all four counters to zero. The same advance raises a one-cycle loop-done pulse, which the surrounding pipeline uses as its move-to-next-instruction indication.

Top module: `vstep_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four counters to zero. `loopDone` is low after that edge.
- R2: While `advance` is low, all four counters keep their values.
- R3: With `packSrc` = 0, the source sub-step is the inner loop. On an advance, if `srcSub` equals `subvl` and `srcStep` is not `vl`-1, `srcStep` increments and `srcSub` clears. In every other case `srcSub` increments.
- R4: With `packSrc` = 1, the source sub-step is the outer loop. On an advance, if `srcStep` equals `vl`-1 and `srcSub` is not `subvl`, `srcSub` increments and `srcStep` clears. In every other case `srcStep` increments.
- R5: The destination counters follow the rules of R3 and R4. They are selected by `unpackDst` and do not depend on `packSrc`.
- R6: `srcEnd` is high exactly when `srcStep` equals `vl`-1. `dstEnd` is high exactly when `dstStep` equals `vl`-1.
- R7: An advance in vector mode is final when either side has its main step at `vl`-1 and its sub-step equal to `subvl`. A final advance clears all four counters and drives `loopDone` high for the cycle that follows that edge. `loopDone` is high only in the cycle after a completing advance.
- R8: An advance with `vecMode` low clears all four counters and raises `loopDone`, whatever the counter state.
- R9: With `vl` = 1 and `subvl` = 0, a single advance from the reset state completes the loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vl | input | 7 | Vector length, 1 to 127 |
| subvl | input | 2 | Sub-vector length minus one |
| packSrc | input | 1 | Source sub-step is the outer loop when set |
| unpackDst | input | 1 | Destination sub-step is the outer loop when set |
| advance | input | 1 | Step strobe, one element position per cycle |
| vecMode | input | 1 | Instruction runs in vector mode |
| srcStep | output | 7 | Source main step |
| srcSub | output | 2 | Source sub-step |
| dstStep | output | 7 | Destination main step |
| dstSub | output | 2 | Destination sub-step |
| srcEnd | output | 1 | Source main step is at `vl`-1 |
| dstEnd | output | 1 | Destination main step is at `vl`-1 |
| loopDone | output | 1 | One-cycle pulse after a completing advance |

## Verification
Every counter value is due one clock edge after the advance that produces it. `loopDone` comes from a register clocked on that same edge, so it appears together with the cleared counters. The end flags are combinational and follow the counters in the same cycle. The bench drives inputs on the falling edge and samples at the next falling edge, half a period after the edge that consumed them. For the single-pulse check it waits one more full cycle with `advance` low and expects `loopDone` to have dropped.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int STEP_W = 7;
  localparam int SUB_W  = 2;

  // strobes from control to the per-side datapath
  typedef struct packed {
    logic stepEn;    // move one element position
    logic clearAll;  // completion or scalar mode: return to zero
  } stepCtl_t;
endpackage

// File: rtl/vstep_side.sv
module vstep_side
  import vstep_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W,
  parameter int SUB_WIDTH  = SUB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  stepCtl_t              ctl,
  input  logic [STEP_WIDTH-1:0] vl,
  input  logic [SUB_WIDTH-1:0]  subvl,
  input  logic                  subOuter,
  output logic [STEP_WIDTH-1:0] step,
  output logic [SUB_WIDTH-1:0]  sub,
  output logic                  stepAtEnd,
  output logic                  subAtEnd
);
  localparam logic [STEP_WIDTH-1:0] STEP_ONE = STEP_WIDTH'(1);
  localparam logic [SUB_WIDTH-1:0]  SUB_ONE  = SUB_WIDTH'(1);

  logic [STEP_WIDTH-1:0] stepNext;
  logic [SUB_WIDTH-1:0]  subNext;

  assign stepAtEnd = (step == (vl - STEP_ONE));
  assign subAtEnd  = (sub == subvl);

  always_comb begin
    stepNext = step;
    subNext  = sub;
    if (subOuter) begin
      if (stepAtEnd && !subAtEnd) begin
        subNext  = sub + SUB_ONE;
        stepNext = '0;
      end else begin
        stepNext = step + STEP_ONE;
      end
    end else begin
      if (subAtEnd && !stepAtEnd) begin
        stepNext = step + STEP_ONE;
        subNext  = '0;
      end else begin
        subNext = sub + SUB_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clearAll) begin
      step <= '0;
      sub  <= '0;
    end else if (ctl.stepEn) begin
      step <= stepNext;
      sub  <= subNext;
    end
  end
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     advance,
  input  logic     vecMode,
  input  logic     srcStepEnd,
  input  logic     srcSubEnd,
  input  logic     dstStepEnd,
  input  logic     dstSubEnd,
  output stepCtl_t ctl,
  output logic     loopDone
);
  logic finalNow;

  assign finalNow     = (srcStepEnd && srcSubEnd) || (dstStepEnd && dstSubEnd);
  assign ctl.stepEn   = advance;
  assign ctl.clearAll = advance && (finalNow || !vecMode);

  always_ff @(posedge clk) begin
    if (rst) loopDone <= 1'b0;
    else     loopDone <= ctl.clearAll;
  end
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
  import vstep_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W,
  parameter int SUB_WIDTH  = SUB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STEP_WIDTH-1:0] vl,
  input  logic [SUB_WIDTH-1:0]  subvl,
  input  logic                  packSrc,
  input  logic                  unpackDst,
  input  logic                  advance,
  input  logic                  vecMode,
  output logic [STEP_WIDTH-1:0] srcStep,
  output logic [SUB_WIDTH-1:0]  srcSub,
  output logic [STEP_WIDTH-1:0] dstStep,
  output logic [SUB_WIDTH-1:0]  dstSub,
  output logic                  srcEnd,
  output logic                  dstEnd,
  output logic                  loopDone
);
  localparam int SIDES = 2;  // index 0 source, 1 destination

  stepCtl_t              ctl;
  logic [SIDES-1:0]      outerSel;
  logic [SIDES-1:0]      stepEndV;
  logic [SIDES-1:0]      subEndV;
  logic [STEP_WIDTH-1:0] stepV [SIDES];
  logic [SUB_WIDTH-1:0]  subV  [SIDES];

  assign outerSel = {unpackDst, packSrc};

  for (genvar g = 0; g < SIDES; g++) begin : gSide
    vstep_side #(.STEP_WIDTH(STEP_WIDTH), .SUB_WIDTH(SUB_WIDTH)) uSide (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl),
      .vl       (vl),
      .subvl    (subvl),
      .subOuter (outerSel[g]),
      .step     (stepV[g]),
      .sub      (subV[g]),
      .stepAtEnd(stepEndV[g]),
      .subAtEnd (subEndV[g])
    );
  end

  vstep_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .vecMode   (vecMode),
    .srcStepEnd(stepEndV[0]),
    .srcSubEnd (subEndV[0]),
    .dstStepEnd(stepEndV[1]),
    .dstSubEnd (subEndV[1]),
    .ctl       (ctl),
    .loopDone  (loopDone)
  );

  assign srcStep = stepV[0];
  assign srcSub  = subV[0];
  assign dstStep = stepV[1];
  assign dstSub  = subV[1];
  assign srcEnd  = stepEndV[0];
  assign dstEnd  = stepEndV[1];
endmodule

// File: rtl/vstep_chk.sv
module vstep_chk #(
  parameter int STEP_WIDTH = 7,
  parameter int SUB_WIDTH  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [STEP_WIDTH-1:0] vl,
  input logic [SUB_WIDTH-1:0]  subvl,
  input logic                  packSrc,
  input logic                  advance,
  input logic                  vecMode,
  input logic [STEP_WIDTH-1:0] srcStep,
  input logic [SUB_WIDTH-1:0]  srcSub,
  input logic [STEP_WIDTH-1:0] dstStep,
  input logic [SUB_WIDTH-1:0]  dstSub,
  input logic                  loopDone
);
  logic srcFinal, dstFinal;
  assign srcFinal = (srcStep == vl - 1'b1) && (srcSub == subvl);
  assign dstFinal = (dstStep == vl - 1'b1) && (dstSub == subvl);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (srcStep == '0 && srcSub == '0 && dstStep == '0 && dstSub == '0 && !loopDone));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(srcStep) && $stable(srcSub) && $stable(dstStep) && $stable(dstSub)));

  // R3
  inner_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && vecMode && !packSrc && !srcFinal && !dstFinal && srcSub != subvl)
      |=> (srcSub == $past(srcSub) + 1'b1 && srcStep == $past(srcStep)));

  // R4
  outer_main_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && vecMode && packSrc && !srcFinal && !dstFinal && srcStep != vl - 1'b1)
      |=> (srcStep == $past(srcStep) + 1'b1 && srcSub == $past(srcSub)));

  // R7
  final_done_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && (srcFinal || dstFinal)) |=> (loopDone && srcStep == '0 && dstStep == '0));

  // R7
  done_only_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance) |=> !loopDone);

  // R8
  scalar_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !vecMode) |=> (loopDone && srcSub == '0 && dstSub == '0));
endmodule

bind vstep_seq vstep_chk #(.STEP_WIDTH(STEP_WIDTH), .SUB_WIDTH(SUB_WIDTH)) u_chk (
  .clk(clk), .rst(rst), .vl(vl), .subvl(subvl), .packSrc(packSrc),
  .advance(advance), .vecMode(vecMode), .srcStep(srcStep), .srcSub(srcSub),
  .dstStep(dstStep), .dstSub(dstSub), .loopDone(loopDone)
);

// File: tb/sim_vstep_seq.sv
`timescale 1ns/1ps
module sim_vstep_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] vl = 7'd4;
  logic [1:0] subvl = 2'd1;
  logic       packSrc = 1'b0, unpackDst = 1'b0, advance = 1'b0, vecMode = 1'b1;
  logic [6:0] srcStep, dstStep;
  logic [1:0] srcSub, dstSub;
  logic       srcEnd, dstEnd, loopDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vstep_seq u0 (
    .clk(clk), .rst(rst), .vl(vl), .subvl(subvl), .packSrc(packSrc),
    .unpackDst(unpackDst), .advance(advance), .vecMode(vecMode),
    .srcStep(srcStep), .srcSub(srcSub), .dstStep(dstStep), .dstSub(dstSub),
    .srcEnd(srcEnd), .dstEnd(dstEnd), .loopDone(loopDone)
  );

  // rows: vl, subvl, pack, unpack, advances, srcStep, srcSub, dstStep, dstSub, done
  localparam int ROWS = 9;
  localparam int tVl [ROWS] = '{4, 4, 4, 3, 2, 1, 2, 2, 127};
  localparam int tSv [ROWS] = '{1, 1, 1, 2, 1, 0, 3, 3, 0};
  localparam int tPk [ROWS] = '{0, 1, 1, 0, 0, 0, 1, 1, 0};
  localparam int tUp [ROWS] = '{0, 0, 0, 1, 0, 0, 1, 0, 0};
  localparam int tN  [ROWS] = '{3, 3, 5, 4, 4, 1, 7, 8, 127};
  localparam int eSs [ROWS] = '{1, 3, 1, 1, 0, 0, 1, 0, 0};
  localparam int eSb [ROWS] = '{1, 0, 1, 1, 0, 0, 3, 0, 0};
  localparam int eDs [ROWS] = '{1, 1, 2, 1, 0, 0, 1, 0, 0};
  localparam int eDb [ROWS] = '{1, 1, 1, 1, 0, 0, 3, 0, 0};
  localparam int eDn [ROWS] = '{0, 0, 0, 0, 1, 1, 0, 1, 1};
  localparam string tReq [ROWS] = '{"R3", "R4", "R4", "R5", "R7", "R9", "R5", "R7", "R7"};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1; advance = 1'b0;
    @(negedge clk) rst = 1'b0;
  endtask

  // n back-to-back advances; returns at the falling edge after the last one
  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) advance = 1'b1;
    end
    @(negedge clk) advance = 1'b0;
  endtask

  task automatic checkState(input string req, input int ss, input int sb,
                            input int ds, input int db, input int dn);
    check(req, "srcStep", int'(srcStep), ss);
    check(req, "srcSub", int'(srcSub), sb);
    check(req, "dstStep", int'(dstStep), ds);
    check(req, "dstSub", int'(dstSub), db);
    check(req, "loopDone", int'(loopDone), dn);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    checkState("R1", 0, 0, 0, 0, 0);

    for (int r = 0; r < ROWS; r++) begin
      vl = 7'(tVl[r]); subvl = 2'(tSv[r]);
      packSrc = tPk[r][0]; unpackDst = tUp[r][0]; vecMode = 1'b1;
      doReset();
      stepN(tN[r]);
      checkState(tReq[r], eSs[r], eSb[r], eDs[r], eDb[r], eDn[r]);
    end

    // R7: done is a single pulse
    vl = 7'd2; subvl = 2'd1; packSrc = 1'b0; unpackDst = 1'b0;
    doReset();
    stepN(4);
    check("R7", "loopDone first", int'(loopDone), 1);
    @(negedge clk);
    check("R7", "loopDone second", int'(loopDone), 0);

    // R2: hold while advance low
    vl = 7'd4; subvl = 2'd1;
    doReset();
    stepN(3);
    repeat (5) @(negedge clk);
    checkState("R2", 1, 1, 1, 1, 0);

    // R6: end flags
    packSrc = 1'b1;
    doReset();
    stepN(3);
    check("R6", "srcEnd", int'(srcEnd), 1);
    check("R6", "dstEnd", int'(dstEnd), 0);
    stepN(2);
    check("R6", "srcEnd after wrap", int'(srcEnd), 0);

    // R8: scalar advance clears mid-loop
    packSrc = 1'b0;
    doReset();
    stepN(3);
    vecMode = 1'b0;
    stepN(1);
    checkState("R8", 0, 0, 0, 0, 1);
    vecMode = 1'b1;

    // R1: reset in mid-loop
    stepN(3);
    doReset();
    checkState("R1", 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule